// File: doc/BRIEF.md
# Descriptor DMA Channel Register File

This block holds the software-visible registers for every channel of a descriptor-driven DMA engine. Each channel owns a control word, a derived status word, a command pointer and three condition-select words. A 32-bit port with a word address reaches all of them. The upper address bits pick the channel and the lower bits pick the register. The block keeps no descriptor data and moves no data. It tells the neighbouring sequencer what to do through three per-channel one-cycle pulses: start fetching, flush, and reload the current descriptor.

A control write does not replace the status word. The written word carries a 16-bit mask in bits 31:16 and a 16-bit value in bits 15:0, and only the status bits selected by the mask take the new value. After the merge, three rules apply in this order:
1. A channel whose run bit goes from 0 to 1 becomes active and loses its dead flag.
2. A set pause bit removes the active flag.
3. A channel whose run bit goes from 1 to 0 loses both the active and the dead flags.

The command pointer is protected while the channel runs. An accepted pointer write is aligned to 16 bytes and requests a descriptor reload.

The status word has this layout: bit 15 RUN, bit 14 PAUSE, bit 13 FLUSH, bit 12 WAKE, bit 11 DEAD, bit 10 ACTIVE, bit 8 BRANCHED, bits 7:0 device status. Bits 31:16, bit 9 and bit 8 are zero in this block.

Word offsets inside a channel window are:

| Offset | Register |
|--------|----------|
| 0 | control |
| 1 | status |
| 2 | command pointer |
| 3 | interrupt select |
| 4 | branch select |
| 5 | wait select |

With the defaults, the word address is `{channel[1:0], offset[5:0]}`, which equals the byte address shifted right by 2.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every register of every channel reads zero, all status, pointer and select outputs are zero, and no pulse is high.
- R2: A control write stores the whole word in the control register, which reads back unchanged. Status bits 15:0 become `(value AND mask AND 0xF0FF) OR (old AND NOT mask)`, where the mask is bits 31:16 of the write and the value is bits 15:0.
- R3: Value bits outside RUN, PAUSE, FLUSH, WAKE and device status (mask 0xF0FF) are ignored. A masked non-writable bit becomes 0, and it is never set from the value.
- R4: When a control write takes RUN from 0 to 1, ACTIVE becomes 1 and DEAD becomes 0.
- R5: When PAUSE is 1 after a control write, ACTIVE is 0, and no start pulse is issued.
- R6: When a control write takes RUN from 1 to 0, ACTIVE and DEAD both become 0.
- R7: A command-pointer write is ignored while RUN or ACTIVE is set. The pointer keeps its value and no load pulse is issued.
- R8: An accepted command-pointer write stores the data with bits 3:0 forced to zero, and it raises that channel's load pulse for one cycle after the write edge.
- R9: After a control write, the channel's start pulse is high for one cycle if ACTIVE is then set, and its flush pulse is high for one cycle if FLUSH is then set.
- R10: The channel is taken from the address bits above the register offset. A write changes only the addressed channel, and only that channel's pulses can fire.
- R11: The status register is read-only, so a write to it has no effect. Offsets 6 and above ignore writes and read zero.
- R12: The three select registers store any 32-bit word, read it back, and drive it on their outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | WADDR_W (8) | Word address: channel in the upper bits, offset in the lower bits |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| status_o | output | NUM_CH*32 | Status word of each channel; channel c is in slice `[c*32 +: 32]` |
| cmd_ptr_o | output | NUM_CH*32 | Command pointer of each channel |
| irq_sel_o | output | NUM_CH*32 | Interrupt select word of each channel |
| br_sel_o | output | NUM_CH*32 | Branch select word of each channel |
| wait_sel_o | output | NUM_CH*32 | Wait select word of each channel |
| start_o | output | NUM_CH | One-cycle pulse: the channel should begin fetching |
| flush_o | output | NUM_CH | One-cycle pulse: a flush is requested |
| load_o | output | NUM_CH | One-cycle pulse: reload the descriptor at the command pointer |

## Verification
Every write result lands on the single clock edge that samples the write strobe. The new status, pointer and select values, and the start, flush and load pulses, are therefore all visible in the cycle that follows, and each pulse drops one cycle later. The bench drives on falling edges. It checks outputs and pulses on the falling edge right after the write edge, and confirms on the next falling edge that the pulses are gone. Read results arrive with rd_valid one cycle after the read strobe. A monitor pops the expected word for each read from a scoreboard queue only when rd_valid is high, so the latency of every read is checked as well as its value.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned STAT_W   = 16;

    // status bit positions
    localparam int unsigned RUN_B    = 15;
    localparam int unsigned PAUSE_B  = 14;
    localparam int unsigned FLUSH_B  = 13;
    localparam int unsigned WAKE_B   = 12;
    localparam int unsigned DEAD_B   = 11;
    localparam int unsigned ACTIVE_B = 10;

    // bits that a control value may change
    localparam logic [STAT_W-1:0] CTRL_WRITABLE = 16'hF0FF;

    // register offsets inside a channel window
    localparam int unsigned OFS_CTRL    = 0;
    localparam int unsigned OFS_STAT    = 1;
    localparam int unsigned OFS_CPTR    = 2;
    localparam int unsigned OFS_IRQSEL  = 3;
    localparam int unsigned OFS_BRSEL   = 4;
    localparam int unsigned OFS_WAITSEL = 5;

    typedef struct packed {
        logic ctrl;
        logic cptr;
        logic irqsel;
        logic brsel;
        logic waitsel;
    } wsel_t;

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
    import dmarf_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned CH_W    = 2,
    parameter int unsigned WADDR_W = IDX_W + CH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] addr,
    output logic [CH_W-1:0]    ch_idx,
    output logic [IDX_W-1:0]   reg_idx,
    output logic [NUM_CH-1:0]  ch_wr,
    output wsel_t              wsel
);

    assign ch_idx  = addr[WADDR_W-1:IDX_W];
    assign reg_idx = addr[IDX_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chwr
        assign ch_wr[c] = wr_en && (ch_idx == CH_W'(c));
    end

    always_comb begin
        wsel.ctrl    = (reg_idx == IDX_W'(OFS_CTRL));
        wsel.cptr    = (reg_idx == IDX_W'(OFS_CPTR));
        wsel.irqsel  = (reg_idx == IDX_W'(OFS_IRQSEL));
        wsel.brsel   = (reg_idx == IDX_W'(OFS_BRSEL));
        wsel.waitsel = (reg_idx == IDX_W'(OFS_WAITSEL));
    end

    // R10
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr) && (wr_en || ch_wr == '0));

endmodule

// File: rtl/dmarf_channel.sv
module dmarf_channel
    import dmarf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  wsel_t             wsel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] status_w,
    output logic [WORD_W-1:0] cptr_q,
    output logic [WORD_W-1:0] irqsel_q,
    output logic [WORD_W-1:0] brsel_q,
    output logic [WORD_W-1:0] waitsel_q,
    output logic              start_p,
    output logic              flush_p,
    output logic              load_p
);

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_nxt;
    logic              busy;
    logic              ctrl_we;
    logic              cptr_take;

    assign busy      = stat_q[RUN_B] || stat_q[ACTIVE_B];
    assign ctrl_we   = wr_hit && wsel.ctrl;
    assign cptr_take = wr_hit && wsel.cptr && !busy;
    assign status_w  = {{(WORD_W-STAT_W){1'b0}}, stat_q};

    // masked merge of the control value, then run/pause side effects
    always_comb begin
        logic [STAT_W-1:0] m;
        logic [STAT_W-1:0] v;
        m = wdata[WORD_W-1:STAT_W];
        v = wdata[STAT_W-1:0] & CTRL_WRITABLE;
        stat_nxt = (v & m) | (stat_q & ~m);
        if (!stat_q[RUN_B] && stat_nxt[RUN_B]) begin
            stat_nxt[ACTIVE_B] = 1'b1;
            stat_nxt[DEAD_B]   = 1'b0;
        end
        if (stat_nxt[PAUSE_B]) begin
            stat_nxt[ACTIVE_B] = 1'b0;
        end
        if (stat_q[RUN_B] && !stat_nxt[RUN_B]) begin
            stat_nxt[ACTIVE_B] = 1'b0;
            stat_nxt[DEAD_B]   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            stat_q    <= '0;
            cptr_q    <= '0;
            irqsel_q  <= '0;
            brsel_q   <= '0;
            waitsel_q <= '0;
            start_p   <= 1'b0;
            flush_p   <= 1'b0;
            load_p    <= 1'b0;
        end else begin
            start_p <= 1'b0;
            flush_p <= 1'b0;
            load_p  <= 1'b0;
            if (ctrl_we) begin
                ctrl_q  <= wdata;
                stat_q  <= stat_nxt;
                start_p <= stat_nxt[ACTIVE_B];
                flush_p <= stat_nxt[FLUSH_B];
            end
            if (cptr_take) begin
                cptr_q <= {wdata[WORD_W-1:4], 4'h0};
                load_p <= 1'b1;
            end
            if (wr_hit && wsel.irqsel)  irqsel_q  <= wdata;
            if (wr_hit && wsel.brsel)   brsel_q   <= wdata;
            if (wr_hit && wsel.waitsel) waitsel_q <= wdata;
        end
    end

    // R5
    pause_blocks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[PAUSE_B] |-> !stat_q[ACTIVE_B]);

    // R6
    run_fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[RUN_B] && $past(stat_q[RUN_B])) |-> (!stat_q[ACTIVE_B] && !stat_q[DEAD_B]));

    // R7
    cptr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wsel.cptr && busy) |=> ($stable(cptr_q) && !load_p));

    // R8
    cptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_p |-> (cptr_q[3:0] == 4'h0));

    // R8
    cptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cptr_take |=> load_p);

    // R9
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> stat_q[ACTIVE_B]);

    // R9
    flush_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_p |-> stat_q[FLUSH_B]);

endmodule

// File: rtl/dmarf_rdmux.sv
module dmarf_rdmux
    import dmarf_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned CH_W   = 2
) (
    input  logic [CH_W-1:0]                 ch_idx,
    input  logic [IDX_W-1:0]                reg_idx,
    input  logic [NUM_CH-1:0][WORD_W-1:0]   ctrl_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0]   stat_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0]   cptr_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0]   irq_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0]   br_v,
    input  logic [NUM_CH-1:0][WORD_W-1:0]   wt_v,
    output logic [WORD_W-1:0]               rdata
);

    always_comb begin
        rdata = '0;
        if (32'(ch_idx) < NUM_CH) begin
            unique case (32'(reg_idx))
                OFS_CTRL:    rdata = ctrl_v[ch_idx];
                OFS_STAT:    rdata = stat_v[ch_idx];
                OFS_CPTR:    rdata = cptr_v[ch_idx];
                OFS_IRQSEL:  rdata = irq_v[ch_idx];
                OFS_BRSEL:   rdata = br_v[ch_idx];
                OFS_WAITSEL: rdata = wt_v[ch_idx];
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
    import dmarf_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned CH_SHIFT = 8,
    localparam int unsigned IDX_W   = CH_SHIFT - 2,
    localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned WADDR_W = IDX_W + CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [WADDR_W-1:0]       addr,
    input  logic [31:0]              wr_data,
    output logic [31:0]              rd_data,
    output logic                     rd_valid,
    output logic [NUM_CH*32-1:0]     status_o,
    output logic [NUM_CH*32-1:0]     cmd_ptr_o,
    output logic [NUM_CH*32-1:0]     irq_sel_o,
    output logic [NUM_CH*32-1:0]     br_sel_o,
    output logic [NUM_CH*32-1:0]     wait_sel_o,
    output logic [NUM_CH-1:0]        start_o,
    output logic [NUM_CH-1:0]        flush_o,
    output logic [NUM_CH-1:0]        load_o
);

    logic [CH_W-1:0]                 ch_idx;
    logic [IDX_W-1:0]                reg_idx;
    logic [NUM_CH-1:0]               ch_wr;
    wsel_t                           wsel;
    logic [NUM_CH-1:0][WORD_W-1:0]   ctrl_v, stat_v, cptr_v, irq_v, br_v, wt_v;
    logic [WORD_W-1:0]               rdata_c;

    dmarf_decode #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W),
        .CH_W   (CH_W)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .ch_idx  (ch_idx),
        .reg_idx (reg_idx),
        .ch_wr   (ch_wr),
        .wsel    (wsel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmarf_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (ch_wr[c]),
            .wsel      (wsel),
            .wdata     (wr_data),
            .ctrl_q    (ctrl_v[c]),
            .status_w  (stat_v[c]),
            .cptr_q    (cptr_v[c]),
            .irqsel_q  (irq_v[c]),
            .brsel_q   (br_v[c]),
            .waitsel_q (wt_v[c]),
            .start_p   (start_o[c]),
            .flush_p   (flush_o[c]),
            .load_p    (load_o[c])
        );
        assign status_o  [c*32 +: 32] = stat_v[c];
        assign cmd_ptr_o [c*32 +: 32] = cptr_v[c];
        assign irq_sel_o [c*32 +: 32] = irq_v[c];
        assign br_sel_o  [c*32 +: 32] = br_v[c];
        assign wait_sel_o[c*32 +: 32] = wt_v[c];
    end

    dmarf_rdmux #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W),
        .CH_W   (CH_W)
    ) u_rdmux (
        .ch_idx  (ch_idx),
        .reg_idx (reg_idx),
        .ctrl_v  (ctrl_v),
        .stat_v  (stat_v),
        .cptr_v  (cptr_v),
        .irq_v   (irq_v),
        .br_v    (br_v),
        .wt_v    (wt_v),
        .rdata   (rdata_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rdata_c;
        end
    end

    // R10
    pulse_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o != '0) |-> $onehot0(load_o));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (start_o == '0 && flush_o == '0 && load_o == '0));

endmodule

// File: tb/test_dma_chan_regfile.sv
module test_dma_chan_regfile;

    localparam int NUM_CH = 4;
    localparam int AW     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic [NUM_CH*32-1:0] status_o, cmd_ptr_o, irq_sel_o, br_sel_o, wait_sel_o;
    logic [NUM_CH-1:0] start_o, flush_o, load_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dma_chan_regfile i_dma_chan_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .status_o   (status_o),
        .cmd_ptr_o  (cmd_ptr_o),
        .irq_sel_o  (irq_sel_o),
        .br_sel_o   (br_sel_o),
        .wait_sel_o (wait_sel_o),
        .start_o    (start_o),
        .flush_o    (flush_o),
        .load_o     (load_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] wa(int ch, int ofs);
        return AW'((ch << 6) | ofs);
    endfunction

    // write, returns on the falling edge after the write edge
    task automatic wr(int ch, int ofs, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = wa(ch, ofs); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: queue the expected word, then issue the read
    task automatic rd(int ch, int ofs, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b1; addr = wa(ch, ofs);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulses(string tag, int ch, bit s, bit f, bit l);
        check({tag, " start"}, 32'(start_o), s ? (32'd1 << ch) : 32'd0);
        check({tag, " flush"}, 32'(flush_o), f ? (32'd1 << ch) : 32'd0);
        check({tag, " load"},  32'(load_o),  l ? (32'd1 << ch) : 32'd0);
    endtask

    // monitor: compare each read result when it appears
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL read-monitor actual=%08h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 status_o", status_o[31:0] | status_o[63:32] | status_o[95:64] | status_o[127:96], 0);
        check("R1 cmd_ptr_o", cmd_ptr_o[63:32], 0);
        pulses("R1", 0, 0, 0, 0);
        rd(1, 1, 32'h0, "R1 status read");
        rd(2, 3, 32'h0, "R1 irqsel read");

        // R8 accepted pointer write, aligned, load pulse
        wr(1, 2, 32'h1234_567F);
        pulses("R8 ptr", 1, 0, 0, 1);
        check("R8 cmd_ptr_o", cmd_ptr_o[63:32], 32'h1234_5670);
        @(negedge clk);
        pulses("R8 after", 1, 0, 0, 0);
        rd(1, 2, 32'h1234_5670, "R8 ptr read");

        // R2 masked merge of device status
        wr(1, 0, 32'h00FF_00A5);
        check("R2 status", status_o[63:32], 32'h0000_00A5);
        pulses("R2", 1, 0, 0, 0);
        rd(1, 0, 32'h00FF_00A5, "R2 ctrl readback");

        // R3 non-writable value bits ignored, masked ones cleared
        wr(1, 0, 32'h0F0F_FFFF);
        check("R3 status", status_o[63:32], 32'h0000_00AF);

        // R4 run rising -> active, start pulse (R9)
        wr(1, 0, 32'h8000_8000);
        check("R4 status", status_o[63:32], 32'h0000_84AF);
        pulses("R4 R9", 1, 1, 0, 0);
        @(negedge clk);
        pulses("R9 after", 1, 0, 0, 0);

        // R7 pointer write while running is ignored
        wr(1, 2, 32'hDEAD_0000);
        pulses("R7", 1, 0, 0, 0);
        rd(1, 2, 32'h1234_5670, "R7 ptr read");

        // R5 pause clears active, no start
        wr(1, 0, 32'h4000_4000);
        check("R5 status", status_o[63:32], 32'h0000_C0AF);
        pulses("R5", 1, 0, 0, 0);

        // R9 flush pulse
        wr(1, 0, 32'h2000_2000);
        check("R9 flush status", status_o[63:32], 32'h0000_E0AF);
        pulses("R9 flush", 1, 0, 1, 0);

        // R6 run falling on channel 2 while active
        wr(2, 0, 32'h8000_8000);
        check("R6 setup", status_o[95:64], 32'h0000_8400);
        wr(2, 0, 32'h8000_0000);
        check("R6 status", status_o[95:64], 32'h0000_0000);
        pulses("R6", 2, 0, 0, 0);

        // channel 1: stop, then pointer accepted again
        wr(1, 0, 32'hC000_0000);
        check("R6 ch1 status", status_o[63:32], 32'h0000_20AF);
        wr(1, 2, 32'h0000_1008);
        pulses("R8 second", 1, 0, 0, 1);
        rd(1, 2, 32'h0000_1000, "R8 ptr read 2");

        // R12 select registers
        wr(3, 3, 32'h000F_0003);
        wr(3, 4, 32'hA5A5_5A5A);
        wr(3, 5, 32'h1234_FEDC);
        check("R12 irq_sel_o", irq_sel_o[127:96], 32'h000F_0003);
        check("R12 br_sel_o", br_sel_o[127:96], 32'hA5A5_5A5A);
        check("R12 wait_sel_o", wait_sel_o[127:96], 32'h1234_FEDC);
        rd(3, 4, 32'hA5A5_5A5A, "R12 brsel read");

        // R11 status read-only, unimplemented offsets
        wr(1, 1, 32'hFFFF_FFFF);
        rd(1, 1, 32'h0000_20AF, "R11 status write ignored");
        wr(1, 7, 32'h0000_0055);
        rd(1, 7, 32'h0, "R11 unimplemented read");

        // R10 untouched channel 0
        check("R10 ch0 status", status_o[31:0], 0);
        check("R10 ch0 ptr", cmd_ptr_o[31:0], 0);
        rd(0, 3, 32'h0, "R10 ch0 irqsel");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL read-monitor actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule